// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one 32-bit instruction word, together with the zero flag from the register test, into every steering signal that a one-instruction-per-cycle datapath needs in the same cycle. It settles how the immediate is widened and which operand feeds the ALU's B input. It also settles the ALU operation, both write enables, the source of the write-back value, the destination register and the source of the next PC. It is purely combinational: the outputs follow the inputs with no register on the way.

Inside, a classifier sorts the opcode and function field into an instruction class and maps each to an ALU operation. A control table turns the class and the zero flag into the select codes. An extender produces the widened immediate in one of three forms. The destination register number is resolved from the rt field, the rd field or the fixed link register. The ALU, register file, PC adders and memories sit outside and consume these outputs.

Top module: `sc_ctrl_decoder`

## Requirements
- R1: Output codes: ext_sel_o sign=0, zero=1, high=2; b_src_o register=0, immediate=1; wb_src_o ALU=0, memory=1, PC=2; dst_sel_o rt=0, rd=1, link=2; pc_src_o next-sequential=0, branch=1, register-indirect=2, absolute=3; alu_op_o ADD=0, SUB=1, AND=2, OR=3, XOR=4, NOR=5, SLT=6, SLTU=7, PASSB=8, ZTEST=9. The opcode is bits 31:26, rt bits 20:16, rd bits 15:11, func bits 5:0 and the immediate bits 15:0. wr_reg_o carries rt when dst_sel_o is 0, rd when it is 1, and 31 when it is 2.
- R2: Opcode 0x00 with func 0x20/0x21 (ADD), 0x22/0x23 (SUB), 0x24 (AND), 0x25 (OR), 0x26 (XOR), 0x27 (NOR), 0x2A (SLT) or 0x2B (SLTU) gives b_src register, that ALU operation, reg_we 1, wb ALU, dst rd, pc next-sequential, mem_we 0.
- R3: Opcodes 0x08, 0x09 (ADD), 0x0A (SLT) and 0x0B (SLTU) give ext sign, b_src immediate, that ALU operation, reg_we 1, wb ALU, dst rt, pc next-sequential, mem_we 0.
- R4: Opcodes 0x0C (AND), 0x0D (OR) and 0x0E (XOR) behave as R3 except that ext is zero.
- R5: Opcode 0x0F gives ext high, with the immediate in output bits 31:16 and zeros in bits 15:0. It also gives b_src immediate, ALU PASSB and a write of the ALU result into rt.
- R6: Opcode 0x23 (load word) gives ext sign, b_src immediate, ALU ADD, reg_we 1, wb memory, dst rt, mem_we 0, pc next-sequential.
- R7: Opcode 0x2B (store word) gives ext sign, b_src immediate, ALU ADD, mem_we 1, reg_we 0, pc next-sequential.
- R8: Opcode 0x04 (branch if zero) and 0x05 (branch if not zero) give ext sign, ALU ZTEST and no write. Zero flag 1 means the tested register is zero. Branch-if-zero selects branch when the flag is 1, branch-if-not-zero when it is 0, and otherwise next-sequential.
- R9: Opcode 0x02 selects absolute with no write. Opcode 0x03 selects absolute, reg_we 1, wb PC, dst link, wr_reg 31, mem_we 0.
- R10: Opcode 0x00 with func 0x08 selects register-indirect with no write. Func 0x09 selects register-indirect, reg_we 1, wb PC, dst link, wr_reg 31.
- R11: Any other opcode, or opcode 0x00 with any other func (0x00 included), gives reg_we 0, mem_we 0 and every select at code 0.
- R12: The zero flag changes no output of a non-branch instruction.
- R13: Sign extension copies immediate bit 15 into bits 31:16 (0x8000 gives 0xFFFF8000, 0x7FFF gives 0x00007FFF); zero extension fills bits 31:16 with zeros (0x8000 gives 0x00008000).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word |
| zero_flag_i | input | 1 | High when the tested register equals zero |
| ext_sel_o | output | 2 | Immediate widening select |
| b_src_o | output | 1 | ALU B operand source |
| alu_op_o | output | 4 | ALU operation |
| mem_we_o | output | 1 | Data memory write enable |
| reg_we_o | output | 1 | Register file write enable |
| wb_src_o | output | 2 | Write-back value source |
| dst_sel_o | output | 2 | Destination register select |
| pc_src_o | output | 2 | Next PC source |
| wr_reg_o | output | 5 | Resolved destination register number |
| imm_o | output | 32 | Widened immediate |

## Verification
The link jumps are where two functions meet in one cycle. The register write of the return address and the redirect of the PC both come from a single instruction. Each link jump is sent with both zero-flag values, and the write enable, PC write-back source, register 31 and the jump target select are all judged in the same sample. Branches are the other overlap, since a zero test and the PC decision coincide. Both branch opcodes are driven with both flag values, and non-branch instructions are repeated with the flag flipped to show that the redirect stays confined to branches.

// File: rtl/scd_pkg.sv
package scd_pkg;

  localparam int INSTR_W = 32;
  localparam int OP_W    = 6;
  localparam int FUNC_W  = 6;
  localparam int REG_AW  = 5;
  localparam int IMM_W   = 16;
  localparam int OP_LSB  = INSTR_W - OP_W;
  localparam int RT_LSB  = 16;
  localparam int RD_LSB  = 11;

  typedef enum logic [1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_HIGH = 2'd2} ext_sel_e;
  typedef enum logic       {BSRC_REG = 1'b0, BSRC_IMM = 1'b1} b_src_e;
  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR = 4'd3,
    ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLT = 4'd6, ALU_SLTU = 4'd7,
    ALU_PASSB = 4'd8, ALU_ZTEST = 4'd9
  } alu_op_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_PC = 2'd2} wb_src_e;
  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_sel_e;
  typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_BRANCH = 2'd1, PC_RIND = 2'd2, PC_JABS = 2'd3} pc_src_e;

  typedef enum logic [3:0] {
    CL_BAD = 4'd0, CL_RR = 4'd1, CL_IMM_S = 4'd2, CL_IMM_U = 4'd3,
    CL_IMM_HI = 4'd4, CL_LOAD = 4'd5, CL_STORE = 4'd6, CL_BR_EQ = 4'd7,
    CL_BR_NE = 4'd8, CL_JUMP = 4'd9, CL_JLINK = 4'd10, CL_JREG = 4'd11,
    CL_JREG_LINK = 4'd12
  } instr_class_e;

  typedef struct packed {
    ext_sel_e ext;
    b_src_e   bsrc;
    alu_op_e  alu;
    logic     mem_we;
    logic     reg_we;
    wb_src_e  wb;
    dst_sel_e dst;
    pc_src_e  pc;
  } ctrl_t;

  localparam logic [OP_W-1:0] OPC_SPECIAL = 6'h00;
  localparam logic [OP_W-1:0] OPC_J       = 6'h02;
  localparam logic [OP_W-1:0] OPC_JAL     = 6'h03;
  localparam logic [OP_W-1:0] OPC_BEQZ    = 6'h04;
  localparam logic [OP_W-1:0] OPC_BNEZ    = 6'h05;
  localparam logic [OP_W-1:0] OPC_ADDI    = 6'h08;
  localparam logic [OP_W-1:0] OPC_ADDIU   = 6'h09;
  localparam logic [OP_W-1:0] OPC_SLTI    = 6'h0A;
  localparam logic [OP_W-1:0] OPC_SLTIU   = 6'h0B;
  localparam logic [OP_W-1:0] OPC_ANDI    = 6'h0C;
  localparam logic [OP_W-1:0] OPC_ORI     = 6'h0D;
  localparam logic [OP_W-1:0] OPC_XORI    = 6'h0E;
  localparam logic [OP_W-1:0] OPC_LUI     = 6'h0F;
  localparam logic [OP_W-1:0] OPC_LW      = 6'h23;
  localparam logic [OP_W-1:0] OPC_SW      = 6'h2B;

  localparam logic [FUNC_W-1:0] FN_JR   = 6'h08;
  localparam logic [FUNC_W-1:0] FN_JALR = 6'h09;
  localparam logic [FUNC_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FUNC_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FUNC_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FUNC_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FUNC_W-1:0] FN_AND  = 6'h24;
  localparam logic [FUNC_W-1:0] FN_OR   = 6'h25;
  localparam logic [FUNC_W-1:0] FN_XOR  = 6'h26;
  localparam logic [FUNC_W-1:0] FN_NOR  = 6'h27;
  localparam logic [FUNC_W-1:0] FN_SLT  = 6'h2A;
  localparam logic [FUNC_W-1:0] FN_SLTU = 6'h2B;

  // ALU operation of a register-register function code; ADD for unknown codes
  function automatic alu_op_e func_alu(input logic [FUNC_W-1:0] fn);
    case (fn)
      FN_ADD, FN_ADDU: return ALU_ADD;
      FN_SUB, FN_SUBU: return ALU_SUB;
      FN_AND:          return ALU_AND;
      FN_OR:           return ALU_OR;
      FN_XOR:          return ALU_XOR;
      FN_NOR:          return ALU_NOR;
      FN_SLT:          return ALU_SLT;
      FN_SLTU:         return ALU_SLTU;
      default:         return ALU_ADD;
    endcase
  endfunction

  function automatic logic func_is_alu(input logic [FUNC_W-1:0] fn);
    case (fn)
      FN_ADD, FN_ADDU, FN_SUB, FN_SUBU, FN_AND,
      FN_OR, FN_XOR, FN_NOR, FN_SLT, FN_SLTU: return 1'b1;
      default:                                return 1'b0;
    endcase
  endfunction

  // ALU operation of an immediate-form opcode
  function automatic alu_op_e opc_alu(input logic [OP_W-1:0] op);
    case (op)
      OPC_ADDI, OPC_ADDIU: return ALU_ADD;
      OPC_SLTI:            return ALU_SLT;
      OPC_SLTIU:           return ALU_SLTU;
      OPC_ANDI:            return ALU_AND;
      OPC_ORI:             return ALU_OR;
      OPC_XORI:            return ALU_XOR;
      OPC_LUI:             return ALU_PASSB;
      default:             return ALU_ADD;
    endcase
  endfunction

  function automatic instr_class_e classify(input logic [OP_W-1:0] op,
                                            input logic [FUNC_W-1:0] fn);
    case (op)
      OPC_SPECIAL: begin
        if (fn == FN_JR)        return CL_JREG;
        else if (fn == FN_JALR) return CL_JREG_LINK;
        else if (func_is_alu(fn)) return CL_RR;
        else                    return CL_BAD;
      end
      OPC_J:                                     return CL_JUMP;
      OPC_JAL:                                   return CL_JLINK;
      OPC_BEQZ:                                  return CL_BR_EQ;
      OPC_BNEZ:                                  return CL_BR_NE;
      OPC_ADDI, OPC_ADDIU, OPC_SLTI, OPC_SLTIU:  return CL_IMM_S;
      OPC_ANDI, OPC_ORI, OPC_XORI:               return CL_IMM_U;
      OPC_LUI:                                   return CL_IMM_HI;
      OPC_LW:                                    return CL_LOAD;
      OPC_SW:                                    return CL_STORE;
      default:                                   return CL_BAD;
    endcase
  endfunction

endpackage

// File: rtl/scd_classify.sv
module scd_classify
  import scd_pkg::*;
(
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [FUNC_W-1:0] func_i,
  output instr_class_e      cls_o,
  output alu_op_e           func_op_o,
  output alu_op_e           imm_op_o
);

  always_comb begin
    cls_o     = classify(opcode_i, func_i);
    func_op_o = func_alu(func_i);
    imm_op_o  = opc_alu(opcode_i);
  end

endmodule

// File: rtl/scd_ctrl_table.sv
module scd_ctrl_table
  import scd_pkg::*;
(
  input  instr_class_e cls_i,
  input  logic         zero_flag_i,
  input  alu_op_e      func_op_i,
  input  alu_op_e      imm_op_i,
  output ctrl_t        ctrl_o
);

  // branch decision: flag high means the tested register is zero
  logic br_taken;
  always_comb begin
    br_taken = 1'b0;
    if (cls_i == CL_BR_EQ) br_taken = zero_flag_i;
    if (cls_i == CL_BR_NE) br_taken = ~zero_flag_i;
  end

  always_comb begin
    ctrl_o = '{ext: EXT_SIGN, bsrc: BSRC_REG, alu: ALU_ADD, mem_we: 1'b0,
               reg_we: 1'b0, wb: WB_ALU, dst: DST_RT, pc: PC_SEQ};
    case (cls_i)
      CL_RR: begin
        ctrl_o.alu    = func_op_i;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.dst    = DST_RD;
      end
      CL_IMM_S, CL_IMM_U, CL_IMM_HI: begin
        ctrl_o.ext    = (cls_i == CL_IMM_U)  ? EXT_ZERO :
                        (cls_i == CL_IMM_HI) ? EXT_HIGH : EXT_SIGN;
        ctrl_o.bsrc   = BSRC_IMM;
        ctrl_o.alu    = imm_op_i;
        ctrl_o.reg_we = 1'b1;
      end
      CL_LOAD: begin
        ctrl_o.bsrc   = BSRC_IMM;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wb     = WB_MEM;
      end
      CL_STORE: begin
        ctrl_o.bsrc   = BSRC_IMM;
        ctrl_o.mem_we = 1'b1;
      end
      CL_BR_EQ, CL_BR_NE: begin
        ctrl_o.alu = ALU_ZTEST;
        ctrl_o.pc  = br_taken ? PC_BRANCH : PC_SEQ;
      end
      CL_JUMP: ctrl_o.pc = PC_JABS;
      CL_JREG: ctrl_o.pc = PC_RIND;
      CL_JLINK, CL_JREG_LINK: begin
        ctrl_o.pc     = (cls_i == CL_JLINK) ? PC_JABS : PC_RIND;
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wb     = WB_PC;
        ctrl_o.dst    = DST_LINK;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/scd_imm_ext.sv
module scd_imm_ext
  import scd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IN_W   = 16
) (
  input  logic [IN_W-1:0]   imm_i,
  input  ext_sel_e          sel_i,
  output logic [DATA_W-1:0] ext_o
);

  localparam int PAD_W = DATA_W - IN_W;

  generate
    if (PAD_W > 0) begin : g_pad
      always_comb begin
        case (sel_i)
          EXT_SIGN: ext_o = {{PAD_W{imm_i[IN_W-1]}}, imm_i};
          EXT_ZERO: ext_o = {{PAD_W{1'b0}}, imm_i};
          EXT_HIGH: ext_o = {imm_i, {PAD_W{1'b0}}};
          default:  ext_o = '0;
        endcase
      end
    end else begin : g_flat
      logic unused_sel;
      assign unused_sel = ^sel_i;
      assign ext_o = imm_i[DATA_W-1:0];
    end
  endgenerate

endmodule

// File: rtl/sc_ctrl_decoder.sv
module sc_ctrl_decoder
  import scd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_REG = 31
) (
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               zero_flag_i,
  output logic [1:0]         ext_sel_o,
  output logic               b_src_o,
  output logic [3:0]         alu_op_o,
  output logic               mem_we_o,
  output logic               reg_we_o,
  output logic [1:0]         wb_src_o,
  output logic [1:0]         dst_sel_o,
  output logic [1:0]         pc_src_o,
  output logic [REG_AW-1:0]  wr_reg_o,
  output logic [DATA_W-1:0]  imm_o
);

  logic [OP_W-1:0]   opcode;
  logic [FUNC_W-1:0] func;
  logic [REG_AW-1:0] rt_f;
  logic [REG_AW-1:0] rd_f;
  logic [IMM_W-1:0]  imm_f;

  assign opcode = instr_i[OP_LSB +: OP_W];
  assign func   = instr_i[FUNC_W-1:0];
  assign rt_f   = instr_i[RT_LSB +: REG_AW];
  assign rd_f   = instr_i[RD_LSB +: REG_AW];
  assign imm_f  = instr_i[IMM_W-1:0];

  instr_class_e cls;
  alu_op_e      func_op;
  alu_op_e      imm_op;
  ctrl_t        ctrl;

  scd_classify u_cls (
    .opcode_i  (opcode),
    .func_i    (func),
    .cls_o     (cls),
    .func_op_o (func_op),
    .imm_op_o  (imm_op)
  );

  scd_ctrl_table u_tbl (
    .cls_i       (cls),
    .zero_flag_i (zero_flag_i),
    .func_op_i   (func_op),
    .imm_op_i    (imm_op),
    .ctrl_o      (ctrl)
  );

  scd_imm_ext #(.DATA_W(DATA_W), .IN_W(IMM_W)) u_ext (
    .imm_i (imm_f),
    .sel_i (ctrl.ext),
    .ext_o (imm_o)
  );

  // named events for the checker
  logic ev_branch;
  logic ev_bad;
  assign ev_branch = (cls == CL_BR_EQ) || (cls == CL_BR_NE);
  assign ev_bad    = (cls == CL_BAD);

  always_comb begin
    case (ctrl.dst)
      DST_RD:   wr_reg_o = rd_f;
      DST_LINK: wr_reg_o = REG_AW'(LINK_REG);
      default:  wr_reg_o = rt_f;
    endcase
  end

  assign ext_sel_o = ctrl.ext;
  assign b_src_o   = ctrl.bsrc;
  assign alu_op_o  = ctrl.alu;
  assign mem_we_o  = ctrl.mem_we;
  assign reg_we_o  = ctrl.reg_we;
  assign wb_src_o  = ctrl.wb;
  assign dst_sel_o = ctrl.dst;
  assign pc_src_o  = ctrl.pc;

endmodule

// File: rtl/scd_checker.sv
module scd_checker
  import scd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int LINK_REG = 31
) (
  input logic [INSTR_W-1:0] instr_i,
  input logic               zero_flag_i,
  input logic [1:0]         ext_sel_o,
  input logic               b_src_o,
  input logic [3:0]         alu_op_o,
  input logic               mem_we_o,
  input logic               reg_we_o,
  input logic [1:0]         wb_src_o,
  input logic [1:0]         dst_sel_o,
  input logic [1:0]         pc_src_o,
  input logic [REG_AW-1:0]  wr_reg_o,
  input logic [DATA_W-1:0]  imm_o,
  input logic               ev_branch,
  input logic               ev_bad
);

  localparam int PAD_W = DATA_W - IMM_W;

  always_comb begin
    if (!$isunknown({instr_i, zero_flag_i})) begin
      // R7
      store_no_regwe_chk: assert (!(mem_we_o && reg_we_o))
        else $error("memory and register write together");
      // R7
      store_addr_form_chk: assert (!mem_we_o || (b_src_o == BSRC_IMM && alu_op_o == ALU_ADD))
        else $error("store without immediate add");
      // R8
      branch_redirect_chk: assert (pc_src_o != PC_BRANCH ||
                                   (alu_op_o == ALU_ZTEST && !reg_we_o && !mem_we_o))
        else $error("branch redirect with wrong control");
      // R12
      zero_only_branch_chk: assert (ev_branch || pc_src_o != PC_BRANCH)
        else $error("non-branch took the branch target");
      // R9
      link_target_chk: assert (!(reg_we_o && wb_src_o == WB_PC) ||
                               (dst_sel_o == DST_LINK && wr_reg_o == REG_AW'(LINK_REG) &&
                                (pc_src_o == PC_RIND || pc_src_o == PC_JABS)))
        else $error("link write without jump");
      // R5
      high_lowzero_chk: assert (ext_sel_o != EXT_HIGH || imm_o[PAD_W-1:0] == '0)
        else $error("high form has nonzero low half");
      // R11
      unknown_quiet_chk: assert (!ev_bad || (!reg_we_o && !mem_we_o && pc_src_o == PC_SEQ))
        else $error("unrecognized instruction has effect");
    end
  end

endmodule

bind sc_ctrl_decoder scd_checker #(.DATA_W(DATA_W), .LINK_REG(LINK_REG)) u_chk (
  .instr_i     (instr_i),
  .zero_flag_i (zero_flag_i),
  .ext_sel_o   (ext_sel_o),
  .b_src_o     (b_src_o),
  .alu_op_o    (alu_op_o),
  .mem_we_o    (mem_we_o),
  .reg_we_o    (reg_we_o),
  .wb_src_o    (wb_src_o),
  .dst_sel_o   (dst_sel_o),
  .pc_src_o    (pc_src_o),
  .wr_reg_o    (wr_reg_o),
  .imm_o       (imm_o),
  .ev_branch   (ev_branch),
  .ev_bad      (ev_bad)
);

// File: tb/tb_sc_ctrl_decoder.sv
module tb_sc_ctrl_decoder;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic        zero  = 1'b0;
  logic [1:0]  ext_sel, wb_src, dst_sel, pc_src;
  logic        b_src, mem_we, reg_we;
  logic [3:0]  alu_op;
  logic [4:0]  wr_reg;
  logic [31:0] imm;

  sc_ctrl_decoder dut (
    .instr_i(instr), .zero_flag_i(zero), .ext_sel_o(ext_sel), .b_src_o(b_src),
    .alu_op_o(alu_op), .mem_we_o(mem_we), .reg_we_o(reg_we), .wb_src_o(wb_src),
    .dst_sel_o(dst_sel), .pc_src_o(pc_src), .wr_reg_o(wr_reg), .imm_o(imm)
  );

  localparam int C_EXT = 1, C_B = 2, C_ALU = 4, C_WB = 8, C_DST = 16;
  localparam int C_ALL = 31;

  typedef struct {
    string       tag;
    logic [31:0] instr;
    logic        zero;
    int          care;
    logic [1:0]  ext;
    logic        bsrc;
    logic [3:0]  alu;
    logic        mwe;
    logic        rwe;
    logic [1:0]  wb;
    logic [1:0]  dst;
    logic [1:0]  pc;
    logic [4:0]  wr;
    logic [31:0] imm;
  } exp_t;

  exp_t q[$];
  int errors = 0;
  int checks = 0;
  bit done = 0;

  function automatic logic [31:0] rword(logic [5:0] fn, logic [4:0] rt, logic [4:0] rd);
    return {6'h00, 5'd3, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] iword(logic [5:0] op, logic [4:0] rt, logic [15:0] v);
    return {op, 5'd7, rt, v};
  endfunction

  // widened immediate from the requirement text
  function automatic logic [31:0] widen(logic [1:0] e, logic [15:0] v);
    case (e)
      2'd0: return 32'($signed(v));
      2'd1: return 32'(v);
      2'd2: return 32'(v) << 16;
      default: return 32'h0;
    endcase
  endfunction

  function automatic exp_t mk(string tag, logic [31:0] ins, logic z, int care,
                              logic [1:0] ext, logic bsrc, logic [3:0] alu,
                              logic mwe, logic rwe, logic [1:0] wb, logic [1:0] dst,
                              logic [1:0] pc, logic [4:0] wr);
    exp_t e;
    e.tag = tag; e.instr = ins; e.zero = z; e.care = care; e.ext = ext;
    e.bsrc = bsrc; e.alu = alu; e.mwe = mwe; e.rwe = rwe; e.wb = wb;
    e.dst = dst; e.pc = pc; e.wr = wr; e.imm = widen(ext, ins[15:0]);
    return e;
  endfunction

  task automatic send(exp_t e);
    @(posedge clk);
    #1;
    instr = e.instr;
    zero  = e.zero;
    q.push_back(e);
  endtask

  exp_t cur;
  bit   ok;
  always @(negedge clk) begin
    if (q.size() > 0) begin
      cur = q.pop_front();
      checks++;
      ok = (mem_we == cur.mwe) && (reg_we == cur.rwe) && (pc_src == cur.pc);
      if ((cur.care & C_EXT) != 0) ok = ok && (ext_sel == cur.ext) && (imm == cur.imm);
      if ((cur.care & C_B)   != 0) ok = ok && (b_src == cur.bsrc);
      if ((cur.care & C_ALU) != 0) ok = ok && (alu_op == cur.alu);
      if ((cur.care & C_WB)  != 0) ok = ok && (wb_src == cur.wb);
      if ((cur.care & C_DST) != 0) ok = ok && (dst_sel == cur.dst) && (wr_reg == cur.wr);
      if (!ok) begin
        errors++;
        $display("FAIL %s instr=%h z=%0d got ext=%0d b=%0d alu=%0d mwe=%0d rwe=%0d wb=%0d dst=%0d pc=%0d wr=%0d imm=%h exp ext=%0d b=%0d alu=%0d mwe=%0d rwe=%0d wb=%0d dst=%0d pc=%0d wr=%0d imm=%h",
                 cur.tag, cur.instr, cur.zero, ext_sel, b_src, alu_op, mem_we, reg_we,
                 wb_src, dst_sel, pc_src, wr_reg, imm, cur.ext, cur.bsrc, cur.alu,
                 cur.mwe, cur.rwe, cur.wb, cur.dst, cur.pc, cur.wr, cur.imm);
      end
    end
  end

  task automatic rr(string tag, logic [5:0] fn, logic [3:0] alu, logic z);
    send(mk(tag, rword(fn, 5'd9, 5'd12), z, C_B | C_ALU | C_WB | C_DST,
            2'd0, 1'b0, alu, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 5'd12));
  endtask

  task automatic immop(string tag, logic [5:0] op, logic [1:0] ext, logic [3:0] alu,
                       logic [15:0] v);
    send(mk(tag, iword(op, 5'd21, v), 1'b0, C_ALL,
            ext, 1'b1, alu, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 5'd21));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    // R11 reset state: all-zero word is SPECIAL with func 0x00, unrecognized
    send(mk("R11 reset word", 32'h0, 1'b0, C_ALL, 2'd0, 1'b0, 4'd0, 1'b0, 1'b0,
            2'd0, 2'd0, 2'd0, 5'd0));
    rst_n = 1'b1;

    // R2 register-register, R1 rd field routed to wr_reg
    rr("R2 add",  6'h20, 4'd0, 1'b0);
    rr("R2 addu", 6'h21, 4'd0, 1'b0);
    rr("R2 sub",  6'h22, 4'd1, 1'b0);
    rr("R2 subu", 6'h23, 4'd1, 1'b0);
    rr("R2 and",  6'h24, 4'd2, 1'b0);
    rr("R2 or",   6'h25, 4'd3, 1'b0);
    rr("R2 xor",  6'h26, 4'd4, 1'b0);
    rr("R2 nor",  6'h27, 4'd5, 1'b0);
    rr("R2 slt",  6'h2A, 4'd6, 1'b0);
    rr("R2 sltu", 6'h2B, 4'd7, 1'b0);
    send(mk("R1 rd field", {6'h00, 5'd1, 5'd2, 5'd31, 5'd0, 6'h20}, 1'b0, C_DST,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b1, 2'd0, 2'd1, 2'd0, 5'd31));

    // R3 signed immediate, R13 sign extension corners
    immop("R3 addi",  6'h08, 2'd0, 4'd0, 16'h1234);
    immop("R13 addiu neg", 6'h09, 2'd0, 4'd0, 16'h8000);
    immop("R13 slti pos",  6'h0A, 2'd0, 4'd6, 16'h7FFF);
    immop("R3 sltiu", 6'h0B, 2'd0, 4'd7, 16'hFFFF);
    // R4 unsigned immediate, R13 zero extension
    immop("R13 andi", 6'h0C, 2'd1, 4'd2, 16'h8000);
    immop("R4 ori",   6'h0D, 2'd1, 4'd3, 16'hFFFF);
    immop("R4 xori",  6'h0E, 2'd1, 4'd4, 16'h00A5);
    // R5 high form
    immop("R5 lui",   6'h0F, 2'd2, 4'd8, 16'hBEEF);

    // R6 load, R7 store
    send(mk("R6 lw", iword(6'h23, 5'd4, 16'hFFF8), 1'b0, C_ALL,
            2'd0, 1'b1, 4'd0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 5'd4));
    send(mk("R7 sw", iword(6'h2B, 5'd6, 16'h0010), 1'b0, C_EXT | C_B | C_ALU,
            2'd0, 1'b1, 4'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 5'd0));

    // R8 branches with both flag values
    send(mk("R8 beqz z1", iword(6'h04, 5'd0, 16'hFFFC), 1'b1, C_EXT | C_ALU,
            2'd0, 1'b0, 4'd9, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 5'd0));
    send(mk("R8 beqz z0", iword(6'h04, 5'd0, 16'h0004), 1'b0, C_EXT | C_ALU,
            2'd0, 1'b0, 4'd9, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 5'd0));
    send(mk("R8 bnez z0", iword(6'h05, 5'd0, 16'h8001), 1'b0, C_EXT | C_ALU,
            2'd0, 1'b0, 4'd9, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 5'd0));
    send(mk("R8 bnez z1", iword(6'h05, 5'd0, 16'h0040), 1'b1, C_EXT | C_ALU,
            2'd0, 1'b0, 4'd9, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 5'd0));

    // R9 absolute jumps, link jump under both flag values
    send(mk("R9 j", {6'h02, 26'h0ABCDEF}, 1'b0, 0,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 5'd0));
    for (int z = 0; z < 2; z++)
      send(mk("R9 jal", {6'h03, 26'h0000100}, z[0], C_WB | C_DST,
              2'd0, 1'b0, 4'd0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd3, 5'd31));

    // R10 register-indirect jumps
    send(mk("R10 jr", rword(6'h08, 5'd0, 5'd0), 1'b1, 0,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd2, 5'd0));
    for (int z = 0; z < 2; z++)
      send(mk("R10 jalr", rword(6'h09, 5'd0, 5'd5), z[0], C_WB | C_DST,
              2'd0, 1'b0, 4'd0, 1'b0, 1'b1, 2'd2, 2'd2, 2'd2, 5'd31));

    // R11 unrecognized opcode and func
    send(mk("R11 bad op", iword(6'h3F, 5'd8, 16'h8000), 1'b1, C_ALL,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 5'd8));
    send(mk("R11 bad func", rword(6'h18, 5'd10, 5'd11), 1'b0, C_ALL,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 5'd10));
    send(mk("R11 bad op 01", iword(6'h01, 5'd2, 16'h0003), 1'b1, C_ALL,
            2'd0, 1'b0, 4'd0, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 5'd2));

    // R12 zero flag has no effect on non-branch instructions
    rr("R12 add z1", 6'h20, 4'd0, 1'b1);
    send(mk("R12 lw z1", iword(6'h23, 5'd4, 16'hFFF8), 1'b1, C_ALL,
            2'd0, 1'b1, 4'd0, 1'b0, 1'b1, 2'd1, 2'd0, 2'd0, 5'd4));
    send(mk("R12 sw z1", iword(6'h2B, 5'd6, 16'h0010), 1'b1, C_EXT | C_B | C_ALU,
            2'd0, 1'b1, 4'd0, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 5'd0));
    send(mk("R12 lui z1", iword(6'h0F, 5'd21, 16'h1357), 1'b1, C_ALL,
            2'd2, 1'b1, 4'd8, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 5'd21));

    while (q.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule